// File: doc/BRIEF.md
# Three-Wire Register Slave

This block is the slave end of a three-wire serial control bus: an active-high chip select, a host-driven serial clock and one shared data line. Behind it sits a bank of eight-bit control registers whose contents are brought out in parallel to the rest of the chip. One further address returns a status byte supplied from outside the block. The host cannot write that byte.

All three bus pins are asynchronous to the block. They pass through synchronizers into a faster system clock, and the block detects serial clock edges in that domain. Each transfer opens with a header octet that holds a 7-bit start address and a direction bit. Data octets follow, and the address advances by one after each octet. Written octets are held in a staging buffer. All of them move into the live registers together on a single load pulse, which fires when chip select goes low. In a read, the slave takes over the shared line and shifts register contents out until chip select drops.

Top module: `tw_3w_slave`

## Requirements
- R1: After reset every register output byte is 0x00 and `sdio_oe` is low.
- R2: The header octet carries the address in its upper 7 bits, MSB first, and the direction bit in bit 0: 0 selects write and 1 selects read. Every octet is 8 bits, MSB first, and write bits are taken on falling serial clock edges.
- R3: The data octets of one sequence go to the start address, then the start address plus 1, and so on. A single sequence can fill all 22 writable registers.
- R4: `regs_o` does not change while chip select is high. All complete staged octets become visible together on the third rising `clk` edge after `cs_i` falls.
- R5: Serial clock and data activity while chip select is low has no effect on any register.
- R6: Octets aimed at address 22 or above are discarded. Address 22 can never be written.
- R7: When chip select drops partway through an octet, only the octets already complete are committed.
- R8: In a read, the slave drives the line from the first rising serial clock edge after the direction bit. It presents the byte at the start address MSB first, changes the line only on rising edges, and continues with successive addresses.
- R9: A read of address 22 returns `status_i`. A read of any higher address returns 0x00.
- R10: `sdio_oe` is high throughout the data phase of a read and goes low, without waiting for a clock, when `cs_i` goes low.
- R11: A read sequence leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Input side of the shared data line |
| status_i | input | 8 | Read-only status byte returned at address 22 |
| sdio_o | output | 1 | Output side of the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| regs_o | output | 176 | Committed registers, byte k at bits [8k+7:8k] |

## Verification
Two conditions are the hardest to reach from the pins: a sequence that runs past the last writable address, and chip select dropping partway through an octet. Both show up only in what gets committed and in what later reads return. The stimulus reaches them by starting writes near the top of the map with more octets than the map can hold, by aiming a header straight at the status address, and by cutting sequences short after a few bits of a data octet or of the header. The bench compares the whole register bank against its model on every clock, so any commit that comes early, comes late or is only partly applied is caught in the cycle where it occurs.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    PH_HDR = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2
  } tw_phase_e;
endpackage

// File: rtl/tw_sync.sv
// Multi-stage synchronizer, one chain per bit.
module tw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= {sr_q[STAGES-2:0], d[b]};
    end
    assign q[b] = sr_q[STAGES-1];
  end
endmodule

// File: rtl/tw_frame.sv
// Serial framing: header decode, write deserialisation, read serialisation.
module tw_frame
  import tw_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 7,
  parameter int WR_REGS = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              sdio_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              load,
  output logic              rd_act,
  output logic              sdio_o,
  output logic              oe
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0]     LAST_BIT = BW'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] WR_LIM   = ADDR_W'(WR_REGS);

  tw_phase_e         ph_q, ph_d;
  logic              sclk_q, cs_q;
  logic [BW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-2:0] sh_q, sh_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_inc;
  logic [DATA_W-1:0] out_q, out_d, byte_w;
  logic              oe_q, oe_d;
  logic              fall, rise;

  assign fall     = cs_s & sclk_q & ~sclk_s;
  assign rise     = cs_s & ~sclk_q & sclk_s;
  assign byte_w   = {sh_q, sdio_s};
  assign addr_inc = (addr_q == '1) ? addr_q : addr_q + 1'b1;
  assign load     = cs_q & ~cs_s;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    addr_d = addr_q;
    out_d  = out_q;
    oe_d   = oe_q;
    wr_en  = 1'b0;
    if (!cs_s) begin
      ph_d  = PH_HDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      case (ph_q)
        PH_HDR, PH_WR: begin
          if (fall) begin
            sh_d  = byte_w[DATA_W-2:0];
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              if (ph_q == PH_HDR) begin
                addr_d = byte_w[DATA_W-1 -: ADDR_W];
                ph_d   = byte_w[0] ? PH_RD : PH_WR;
              end else begin
                wr_en  = (addr_q < WR_LIM);
                addr_d = addr_inc;
              end
            end
          end
        end
        PH_RD: begin
          if (rise) begin
            oe_d  = 1'b1;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == '0) begin
              out_d  = rd_data;
              addr_d = addr_inc;
            end else begin
              out_d = {out_q[DATA_W-2:0], 1'b0};
            end
          end
        end
        default: ph_d = PH_HDR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_HDR;
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      addr_q <= '0;
      out_q  <= '0;
      oe_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      addr_q <= addr_d;
      out_q  <= out_d;
      oe_q   <= oe_d;
    end
  end

  assign wr_addr = addr_q;
  assign wr_data = byte_w;
  assign rd_addr = addr_q;
  assign rd_act  = (ph_q == PH_RD);
  assign sdio_o  = out_q[DATA_W-1];
  assign oe      = oe_q;
endmodule

// File: rtl/tw_bank.sv
// Staged register bank with a single commit pulse and read multiplexer.
module tw_bank #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 7,
  parameter int WR_REGS = 22
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      load,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [DATA_W-1:0]         status_i,
  output logic [DATA_W-1:0]         rd_data,
  output logic [WR_REGS*DATA_W-1:0] regs_o
);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(WR_REGS);

  for (genvar g = 0; g < WR_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] stg_q, reg_q, reg_d;
    logic              vld_q, vld_d, stg_we;

    always_comb begin
      stg_we = wr_en && (wr_addr == ADDR_W'(g));
      vld_d  = vld_q;
      reg_d  = reg_q;
      if (stg_we) vld_d = 1'b1;
      if (load) begin
        if (vld_q) reg_d = stg_q;
        vld_d = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (stg_we) stg_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        reg_q <= '0;
        vld_q <= 1'b0;
      end else begin
        reg_q <= reg_d;
        vld_q <= vld_d;
      end
    end

    assign regs_o[g*DATA_W +: DATA_W] = reg_q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == STAT_ADDR) rd_data = status_i;
    for (int i = 0; i < WR_REGS; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = regs_o[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/tw_3w_slave.sv
module tw_3w_slave #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int WR_REGS     = 22,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_i,
  input  logic                      sclk_i,
  input  logic                      sdio_i,
  input  logic [DATA_W-1:0]         status_i,
  output logic                      sdio_o,
  output logic                      sdio_oe,
  output logic [WR_REGS*DATA_W-1:0] regs_o
);
  logic [1:0]        rst_sr_q;
  logic              rst_core_n;
  logic [2:0]        pins_s;
  logic              cs_s_w, sclk_s_w, sdio_s_w;
  logic              wr_en_w, load_w, rd_act_w, oe_w;
  logic [ADDR_W-1:0] wr_addr_w, rd_addr_w;
  logic [DATA_W-1:0] wr_data_w, rd_data_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr_q <= '0;
    else        rst_sr_q <= {rst_sr_q[0], 1'b1};
  end
  assign rst_core_n = rst_sr_q[1];

  tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     ({cs_i, sclk_i, sdio_i}),
    .q     (pins_s)
  );
  assign {cs_s_w, sclk_s_w, sdio_s_w} = pins_s;

  tw_frame #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WR_REGS(WR_REGS)) u_frame (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .cs_s    (cs_s_w),
    .sclk_s  (sclk_s_w),
    .sdio_s  (sdio_s_w),
    .rd_data (rd_data_w),
    .wr_en   (wr_en_w),
    .wr_addr (wr_addr_w),
    .wr_data (wr_data_w),
    .rd_addr (rd_addr_w),
    .load    (load_w),
    .rd_act  (rd_act_w),
    .sdio_o  (sdio_o),
    .oe      (oe_w)
  );

  tw_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WR_REGS(WR_REGS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (wr_en_w),
    .wr_addr  (wr_addr_w),
    .wr_data  (wr_data_w),
    .load     (load_w),
    .rd_addr  (rd_addr_w),
    .status_i (status_i),
    .rd_data  (rd_data_w),
    .regs_o   (regs_o)
  );

  // Drive enable falls with the raw chip select, no clock needed.
  assign sdio_oe = oe_w & cs_i;
endmodule

// File: rtl/tw_3w_slave_chk.sv
module tw_3w_slave_chk #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 7,
  parameter int WR_REGS = 22
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sdio_oe,
  input logic [WR_REGS*DATA_W-1:0] regs_o,
  input logic                      load,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         wr_addr,
  input logic                      rd_act,
  input logic                      cs_s
);
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(regs_o)); // R4
  AST_NO_LOAD_DURING_WR: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !wr_en); // R4
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < ADDR_W'(WR_REGS))); // R6
  AST_NO_WR_WITHOUT_CS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cs_s); // R5
  AST_RD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |-> !wr_en); // R11
  AST_OE_ONLY_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> rd_act); // R8
  AST_OE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> !sdio_oe); // R10
endmodule

bind tw_3w_slave tw_3w_slave_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WR_REGS(WR_REGS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sdio_oe (sdio_oe),
  .regs_o  (regs_o),
  .load    (load_w),
  .wr_en   (wr_en_w),
  .wr_addr (wr_addr_w),
  .rd_act  (rd_act_w),
  .cs_s    (cs_s_w)
);

// File: tb/tw_3w_slave_bench.sv
`timescale 1ns/1ps
module tw_3w_slave_bench;
  localparam int NREG = 22;
  localparam int H    = 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cs_i, sclk_i, sdio_i;
  logic [7:0]      status_i;
  logic            sdio_o, sdio_oe;
  logic [NREG*8-1:0] regs_o;

  int vec = 0;
  int mis = 0;
  bit mon_en = 0;
  bit done = 0;
  int exp_r [NREG];
  int pend_a[$];
  int pend_d[$];
  int wbuf [32];

  always #10 clk = ~clk;

  tw_3w_slave u_tw_3w_slave (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sclk_i(sclk_i), .sdio_i(sdio_i),
    .status_i(status_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .regs_o(regs_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    vec++;
    if (act != exp) begin
      mis++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int model_rd(input int a);
    if (a < NREG)  return exp_r[a];
    if (a == NREG) return int'(status_i);
    return 0;
  endfunction

  // Whole-bank comparison on every clock (R4, R5, R11), drive enable (R10).
  always @(negedge clk) begin
    if (mon_en) begin
      for (int r = 0; r < NREG; r++) chk("R4 bank", int'(regs_o[r*8 +: 8]), exp_r[r]);
      if (!cs_i) chk("R10 oe without cs", int'(sdio_oe), 0);
    end
  end

  task automatic sbit(input bit b);
    sdio_i = b; sclk_i = 1'b1; tick(H);
    sclk_i = 1'b0; tick(H);
  endtask

  task automatic sbyte(input int v);
    for (int i = 7; i >= 0; i--) sbit(v[i]);
  endtask

  task automatic cs_on();
    cs_i = 1'b1; tick(4);
  endtask

  task automatic cs_off();
    cs_i = 1'b0;
    #1 chk("R10 oe released", int'(sdio_oe), 0);
    repeat (3) @(posedge clk);
    #1;
    while (pend_a.size() > 0) begin
      int a, d;
      a = pend_a.pop_front();
      d = pend_d.pop_front();
      if (a < NREG) exp_r[a] = d;
    end
    tick(4);
  endtask

  task automatic wr_seq(input int a, input int n, input int partial);
    cs_on();
    sbyte({a[6:0], 1'b0});
    for (int k = 0; k < n; k++) begin
      sbyte(wbuf[k]);
      pend_a.push_back(a + k);
      pend_d.push_back(wbuf[k] & 8'hFF);
    end
    for (int p = 0; p < partial; p++) sbit(1'b1);
    cs_off();
  endtask

  task automatic rd_seq(input int a, input int n, input string tag);
    cs_on();
    sbyte({a[6:0], 1'b1});
    sdio_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      int e;
      e = model_rd(a + k);
      for (int i = 7; i >= 0; i--) begin
        sclk_i = 1'b1; tick(H);
        chk("R10 oe in read", int'(sdio_oe), 1);
        if (a + k >= NREG) chk("R9 status/beyond", int'(sdio_o), e[i]);
        else               chk(tag, int'(sdio_o), e[i]);
        sclk_i = 1'b0; tick(H);
      end
    end
    cs_off();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mis++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_i = 1'b0; sclk_i = 1'b0; sdio_i = 1'b0; status_i = 8'hA5;
    for (int r = 0; r < NREG; r++) exp_r[r] = 0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1: reset state
    for (int r = 0; r < NREG; r++) chk("R1 reset reg", int'(regs_o[r*8 +: 8]), 0);
    chk("R1 reset oe", int'(sdio_oe), 0);
    mon_en = 1'b1;

    // R3: fill the whole bank in one sequence, R8 read it back with overrun
    for (int k = 0; k < 32; k++) wbuf[k] = ((k * 37) + 11) & 8'hFF;
    wr_seq(0, 22, 0);
    rd_seq(0, 25, "R3 incrementing readback");

    // R2: single write, bit order and header decode
    wbuf[0] = 8'hC3;
    wr_seq(5, 1, 0);
    rd_seq(4, 3, "R2 single write readback");

    // R5: clock and data activity with chip select low
    for (int i = 0; i < 10; i++) begin
      sdio_i = i[0]; sclk_i = 1'b1; tick(H); sclk_i = 1'b0; tick(H);
    end
    chk("R5 reg5 untouched", int'(regs_o[5*8 +: 8]), 8'hC3);
    wbuf[0] = 8'h81;
    wr_seq(9, 1, 0);
    rd_seq(9, 1, "R5 clean write after idle activity");

    // R6: overrun past the writable range and a header aimed at the status byte
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr_seq(20, 4, 0);
    rd_seq(20, 5, "R6 overrun readback");
    wbuf[0] = 8'h66; wbuf[1] = 8'h77;
    wr_seq(22, 2, 0);
    rd_seq(21, 3, "R6 status not writable");

    // R7: sequence cut inside an octet, and cut inside the header
    wbuf[0] = 8'h5E; wbuf[1] = 8'hFF;
    wr_seq(3, 1, 5);
    chk("R7 addr3 committed", int'(regs_o[3*8 +: 8]), 8'h5E);
    chk("R7 addr4 kept", int'(regs_o[4*8 +: 8]), model_rd(4));
    cs_on();
    sbit(1'b0); sbit(1'b0); sbit(1'b1); sbit(1'b1);
    cs_off();
    rd_seq(3, 2, "R7 partial readback");

    // R11 and R9: repeated reads leave the bank alone, status follows its input
    status_i = 8'h3C;
    rd_seq(22, 1, "R9 status");
    rd_seq(0, 22, "R11 repeated read");
    rd_seq(0, 22, "R11 repeated read");

    tick(10);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end
endmodule